// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the control state machine for a single-item vending machine whose item costs three units. A coin detector upstream produces a one-cycle pulse for each inserted coin: one line for a one-unit coin, another for a two-unit coin. The controller keeps the running credit for the current purchase. It raises a release strobe, and where needed a one-unit change strobe, in the same cycle as the coin that completes payment.

After a sale the controller spends one cycle in a paid state, which records three or four units. It then falls back to zero credit whatever the inputs are. A deposit can never exceed four units, so a single change strobe always covers the overpayment. Reset is synchronous and active high. Credit is held as a plain binary count of units on three bits (0 to 4), and the codes 5 to 7 are never used.

Top module: `coin_vend_ctrl`

## Requirements
- R1: From zero credit, coins add their value (one unit on `coin_one`, two units on `coin_two`) to the credit, and `release_o` and `change_o` stay low while the new total stays below three units.
- R2: `release_o` is high, combinationally, in the same cycle as the coin that brings the total to three or four units, and at no other time.
- R3: `change_o` is high only in the same cycle as a two-unit coin inserted at two units of credit (a total of four). It is never high without `release_o`.
- R4: In the cycle after a sale, the controller is in its paid state. A coin in that cycle is discarded, both outputs stay low, and the credit is zero on the following cycle.
- R5: With no coin pulse, credit below three units is held unchanged.
- R6: A cycle with `coin_one` and `coin_two` both high is ignored: the credit is held and both outputs stay low.
- R7: While `rst` is high, both outputs are low whatever the coin inputs are. On the clock edge with `rst` high, the credit becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_one | input | 1 | One-cycle pulse for a one-unit coin |
| coin_two | input | 1 | One-cycle pulse for a two-unit coin |
| release_o | output | 1 | Item release strobe, valid in the cycle of the paying coin |
| change_o | output | 1 | One-unit change strobe, valid together with the release |

## Verification
Release and change can fall in the same cycle: a two-unit coin arriving at two units of credit pays and overpays at once. The bench reaches this both from a two-unit coin and from two one-unit coins, and expects both strobes together. It also expects release alone when the total is exactly three. A second overlap tested is reset with a coin pulse. The bench builds up two units of credit, then holds reset during a coin that would pay. Both strobes must stay low, and a later sale must need a full three units again.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    COIN_NONE  = 2'b00,
    COIN_SMALL = 2'b01,
    COIN_LARGE = 2'b10,
    COIN_CLASH = 2'b11
  } coin_kind_e;

  // Sort the two detector pulses into one event kind.
  function automatic coin_kind_e classify_coin(input logic one, input logic two);
    coin_kind_e k;
    case ({two, one})
      2'b01:   k = COIN_SMALL;
      2'b10:   k = COIN_LARGE;
      2'b11:   k = COIN_CLASH;
      default: k = COIN_NONE;
    endcase
    return k;
  endfunction

  // Unit value of a coin event; a clash or no coin is worth nothing.
  function automatic int unsigned coin_units(input coin_kind_e k,
                                             input int unsigned small_v,
                                             input int unsigned large_v);
    int unsigned v;
    case (k)
      COIN_SMALL: v = small_v;
      COIN_LARGE: v = large_v;
      default:    v = 0;
    endcase
    return v;
  endfunction

  // Payment complete once the total meets the price.
  function automatic logic reaches_price(input int unsigned total,
                                         input int unsigned price);
    return total >= price;
  endfunction

  // Overpayment owed back to the customer.
  function automatic logic owes_change(input int unsigned total,
                                       input int unsigned price);
    return total > price;
  endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
#(
  parameter int unsigned SMALL_UNITS = 1,
  parameter int unsigned LARGE_UNITS = 2,
  parameter int unsigned AMT_W       = 2
) (
  input  logic             coin_one,
  input  logic             coin_two,
  output coin_kind_e       kind,
  output logic             coin_seen,
  output logic [AMT_W-1:0] amt
);

  always_comb begin
    kind      = classify_coin(coin_one, coin_two);
    coin_seen = (kind == COIN_SMALL) || (kind == COIN_LARGE);
    amt       = AMT_W'(coin_units(kind, SMALL_UNITS, LARGE_UNITS));
  end

endmodule

// File: rtl/vend_step.sv
module vend_step
  import vend_pkg::*;
#(
  parameter int unsigned PRICE   = 3,
  parameter int unsigned MAX_DEP = 4,
  parameter int unsigned CRED_W  = 3,
  parameter int unsigned AMT_W   = 2
) (
  input  logic [CRED_W-1:0] credit_q,
  input  logic              coin_seen,
  input  logic [AMT_W-1:0]  amt,
  output logic [CRED_W-1:0] credit_d,
  output logic              sale,
  output logic              refund,
  output logic              paid_st
);

  int unsigned cr;
  int unsigned total;
  logic        bad_code;

  always_comb begin
    cr       = 32'(credit_q);
    total    = cr + 32'(amt);
    bad_code = cr > MAX_DEP;
    paid_st  = !bad_code && reaches_price(cr, PRICE);
    credit_d = credit_q;
    sale     = 1'b0;
    refund   = 1'b0;
    if (bad_code || paid_st) begin
      // paid states and unused codes drain back to idle
      credit_d = '0;
    end else if (coin_seen) begin
      credit_d = CRED_W'(total);
      sale     = reaches_price(total, PRICE);
      refund   = owes_change(total, PRICE);
    end
  end

endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg #(
  parameter int unsigned CRED_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CRED_W-1:0] credit_d,
  output logic [CRED_W-1:0] credit_q
);

  always_ff @(posedge clk) begin
    if (rst) credit_q <= '0;
    else     credit_q <= credit_d;
  end

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned PRICE       = 3,
  parameter int unsigned SMALL_UNITS = 1,
  parameter int unsigned LARGE_UNITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic coin_one,
  input  logic coin_two,
  output logic release_o,
  output logic change_o
);

  localparam int unsigned MAX_DEP = PRICE - 1 + LARGE_UNITS;
  localparam int unsigned CRED_W  = $clog2(MAX_DEP + 1);
  localparam int unsigned AMT_W   = $clog2(LARGE_UNITS + 1);

  coin_kind_e        coin_kind;
  logic              coin_seen;
  logic [AMT_W-1:0]  coin_amt;
  logic [CRED_W-1:0] credit_q;
  logic [CRED_W-1:0] credit_d;
  logic              sale_ev;
  logic              refund_ev;
  logic              paid_st;

  vend_coin_decode #(
    .SMALL_UNITS(SMALL_UNITS),
    .LARGE_UNITS(LARGE_UNITS),
    .AMT_W      (AMT_W)
  ) u_decode (
    .coin_one (coin_one),
    .coin_two (coin_two),
    .kind     (coin_kind),
    .coin_seen(coin_seen),
    .amt      (coin_amt)
  );

  vend_step #(
    .PRICE  (PRICE),
    .MAX_DEP(MAX_DEP),
    .CRED_W (CRED_W),
    .AMT_W  (AMT_W)
  ) u_step (
    .credit_q (credit_q),
    .coin_seen(coin_seen),
    .amt      (coin_amt),
    .credit_d (credit_d),
    .sale     (sale_ev),
    .refund   (refund_ev),
    .paid_st  (paid_st)
  );

  vend_credit_reg #(
    .CRED_W(CRED_W)
  ) u_credit (
    .clk     (clk),
    .rst     (rst),
    .credit_d(credit_d),
    .credit_q(credit_q)
  );

  // Mealy strobes, silenced while reset is held
  assign release_o = sale_ev   && !rst;
  assign change_o  = refund_ev && !rst;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int unsigned PRICE       = 3,
  parameter int unsigned SMALL_UNITS = 1,
  parameter int unsigned MAX_DEP     = 4,
  parameter int unsigned CRED_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              coin_one,
  input logic              coin_two,
  input logic              release_o,
  input logic              change_o,
  input logic              paid_st,
  input logic [CRED_W-1:0] credit_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> credit_q == '0); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!release_o && !change_o)); // R7

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(credit_q) <= MAX_DEP); // R1

  AST_SMALL_ADDS: assert property (@(posedge clk) disable iff (rst)
    (32'(credit_q) < PRICE && coin_one && !coin_two)
      |=> 32'(credit_q) == 32'($past(credit_q)) + SMALL_UNITS); // R1

  AST_RELEASE_ON_COIN: assert property (@(posedge clk) disable iff (rst)
    release_o |-> (coin_one != coin_two)); // R2

  AST_RELEASE_PAYS: assert property (@(posedge clk) disable iff (rst)
    release_o |=> paid_st); // R2

  AST_CHANGE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    change_o |-> release_o); // R3

  AST_PAID_RETURNS: assert property (@(posedge clk) disable iff (rst)
    paid_st |=> credit_q == '0); // R4

  AST_PAID_SILENT: assert property (@(posedge clk) disable iff (rst)
    paid_st |-> (!release_o && !change_o)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (32'(credit_q) < PRICE && !coin_one && !coin_two) |=> $stable(credit_q)); // R5

  AST_CLASH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (32'(credit_q) < PRICE && coin_one && coin_two) |=> $stable(credit_q)); // R6

endmodule

bind coin_vend_ctrl vend_ctrl_chk #(
  .PRICE      (PRICE),
  .SMALL_UNITS(SMALL_UNITS),
  .MAX_DEP    (MAX_DEP),
  .CRED_W     (CRED_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .coin_one (coin_one),
  .coin_two (coin_two),
  .release_o(release_o),
  .change_o (change_o),
  .paid_st  (paid_st),
  .credit_q (credit_q)
);

// File: tb/coin_vend_ctrl_bench.sv
`timescale 1ns/1ps
module coin_vend_ctrl_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_one = 1'b0;
  logic coin_two = 1'b0;
  logic release_o;
  logic change_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  coin_vend_ctrl u_coin_vend_ctrl (
    .clk      (clk),
    .rst      (rst),
    .coin_one (coin_one),
    .coin_two (coin_two),
    .release_o(release_o),
    .change_o (change_o)
  );

  // {req[3:0], rst, one, two, exp_release, exp_change}
  localparam int NV = 31;
  localparam logic [8:0] VEC [NV] = '{
    {4'd7, 5'b1_00_00}, // R7 reset
    {4'd5, 5'b0_00_00}, // R5 idle at 0
    {4'd1, 5'b0_10_00}, // R1 0->1
    {4'd1, 5'b0_10_00}, // R1 1->2
    {4'd2, 5'b0_10_10}, // R2 2->3 sale
    {4'd4, 5'b0_10_00}, // R4 coin lost in paid state
    {4'd1, 5'b0_01_00}, // R1 0->2
    {4'd3, 5'b0_01_11}, // R3 2->4 sale with change
    {4'd4, 5'b0_01_00}, // R4 coin lost in paid state
    {4'd1, 5'b0_10_00}, // R1 0->1
    {4'd2, 5'b0_01_10}, // R2 1->3
    {4'd4, 5'b0_00_00}, // R4 paid -> 0
    {4'd1, 5'b0_01_00}, // R1 0->2
    {4'd5, 5'b0_00_00}, // R5 hold 2
    {4'd2, 5'b0_10_10}, // R2 2->3
    {4'd4, 5'b0_00_00}, // R4
    {4'd6, 5'b0_11_00}, // R6 clash at 0
    {4'd1, 5'b0_10_00}, // R1 0->1
    {4'd6, 5'b0_11_00}, // R6 clash at 1
    {4'd6, 5'b0_01_10}, // R6 credit was held at 1 -> 3
    {4'd4, 5'b0_00_00}, // R4
    {4'd1, 5'b0_01_00}, // R1 0->2
    {4'd7, 5'b1_01_00}, // R7 paying coin under reset
    {4'd7, 5'b0_10_00}, // R7 credit restarted: 0->1
    {4'd1, 5'b0_10_00}, // R1 1->2
    {4'd3, 5'b0_01_11}, // R3 2->4 via two small coins first
    {4'd4, 5'b0_00_00}, // R4
    {4'd1, 5'b0_01_00}, // R1 0->2
    {4'd6, 5'b0_11_00}, // R6 clash at 2
    {4'd3, 5'b0_01_11}, // R3 2->4
    {4'd4, 5'b0_00_00}  // R4
  };

  task automatic check(input string req, input logic act_r, input logic act_c,
                       input logic exp_r, input logic exp_c);
    checks++;
    if (act_r !== exp_r || act_c !== exp_c) begin
      errors++;
      $display("FAIL %s: release/change got %b%b expected %b%b at %0t",
               req, act_r, act_c, exp_r, exp_c, $time);
    end
  endtask

  task automatic step(input logic r, input logic one, input logic two);
    @(negedge clk);
    rst = r; coin_one = one; coin_two = two;
    #1;
  endtask

  always @(posedge clk) cycles++;

  initial begin
    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      check($sformatf("R%0d", VEC[i][8:5]), release_o, change_o, VEC[i][1], VEC[i][0]);
    end

    // R7: long reset with coins arriving, then a full price is needed
    step(1'b0, 1'b0, 1'b1);             // credit 2
    check("R1", release_o, change_o, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R7", release_o, change_o, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    check("R7", release_o, change_o, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);             // 0->1
    check("R7", release_o, change_o, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);             // 1->2
    check("R1", release_o, change_o, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);             // 2->3
    check("R2", release_o, change_o, 1'b1, 1'b0);

    // R5: long idle at 1 unit, then a two-unit coin pays exactly
    step(1'b0, 1'b0, 1'b0);             // paid -> 0
    step(1'b0, 1'b1, 1'b0);             // 0->1
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0, 1'b0);
      check("R5", release_o, change_o, 1'b0, 1'b0);
    end
    step(1'b0, 1'b0, 1'b1);
    check("R5", release_o, change_o, 1'b1, 1'b0);

    // R4: back-to-back coins across a sale
    step(1'b0, 1'b0, 1'b1);             // lost in paid state
    check("R4", release_o, change_o, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);             // 0->2
    check("R4", release_o, change_o, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);             // 2->4
    check("R3", release_o, change_o, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait (cycles > 2000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: cycles got %0d expected below 2000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule